// File: doc/BRIEF.md
# Byte-Lane Unified Instruction and Data Memory

This block is the single on-chip memory of a small 32-bit soft processor. The same bytes hold both code and data. Storage is split into four 8-bit banks, one for each byte position of a 32-bit little-endian word. The banks are sized so that each one can map onto its own block RAM.

One port is read-only. It takes a word index and returns a whole instruction word one clock later. The other port serves loads and stores at byte, halfword or word size, using byte addresses counted from zero. That port turns the access size and the low address bits into per-bank write strobes on stores, and into a right-aligned, zero-extended result on loads.

The block also presents the fixed byte address of the first instruction after reset, word index 99. The processor core advances the fetch index from there. Initial contents come from a parameterized arithmetic pattern.

Top module: `lane_mem`

## Requirements
- R1: Four 8-bit banks of DEPTH entries (default 1024). Bank k holds bits [8k+7:8k] of every word. The initial value of lane k of word i is (3*i + 64*k + INIT_SEED) mod 256, with INIT_SEED defaulting to 0x3C.
- R2: `boot_pc` always equals 4*BOOT_WORD, which is 0x0000018C by default (word index 99). While `rst_n` is low, `if_data` and `d_rdata` read zero after a clock edge.
- R3: `if_data` in the cycle after `if_addr` is presented equals the word held at that index.
- R4: A data read (`d_en`=1, `d_we`=0) delivers its result on `d_rdata` in the next cycle. A word read returns the full word. `d_rdata` keeps its value through cycles with stores or no access.
- R5: `d_size`=0 is byte size. A byte load returns lane `d_addr[1:0]` in bits [7:0], with the upper bits zero.
- R6: `d_size`=1 is halfword size. A halfword load returns lanes {3,2} when `d_addr[1]`=1 and lanes {1,0} otherwise, zero-extended. `d_addr[0]` is ignored.
- R7: A byte store writes `d_wdata[7:0]` into lane `d_addr[1:0]` only. The other three lanes of that word are unchanged.
- R8: A halfword store writes `d_wdata[15:0]` into the lane pair chosen as in R6. `d_size`=2 or 3 is word size: it writes all four lanes and ignores `d_addr[1:0]`.
- R9: Both ports share one storage. A word stored through the data port is fetched by the instruction port, and a byte load at byte address 0x18C returns the lowest byte of word 99.
- R10: When a store and a fetch hit the same word in the same cycle, `if_data` returns the old word. A later fetch returns the new one.
- R11: A data address with any bit at or above log2(DEPTH)+2 set (bit 12 and up by default) is out of range. A store there changes nothing, and a load there returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the read registers |
| boot_pc | output | 32 | Byte address of the first fetch after reset |
| if_addr | input | AW (10) | Instruction word index |
| if_data | output | 32 | Instruction word, one cycle after the index |
| d_en | input | 1 | Data access request |
| d_we | input | 1 | 1 = store, 0 = load |
| d_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| d_addr | input | 32 | Data byte address |
| d_wdata | input | 32 | Store data, right-aligned |
| d_rdata | output | 32 | Load result, right-aligned and zero-extended |

## Verification
The bench focuses on four risks:
- **Lane steering at every offset.** A lane decode error would corrupt neighbouring bytes on a sub-word store, or return the wrong byte on a load.
- **Same-word fetch and store collision.** A write-first implementation would leak the new word into the fetch in the collision cycle.
- **Out-of-range accesses.** These would alias onto low memory if the upper address bits were dropped.
- **Hold of the load result across stores and idle cycles.** A load register that updates on every cycle would fail this.

Thousands of seeded random mixed accesses, some of them deliberately colliding and some out of range, are checked against a byte-accurate bench model.

// File: rtl/lane_mem.sv
module lane_mem #(
  parameter int DEPTH     = 1024,
  parameter int BOOT_WORD = 99,
  parameter int INIT_SEED = 8'h3C,
  localparam int AW       = $clog2(DEPTH),
  localparam int BAW      = AW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [31:0]   boot_pc,
  input  logic [AW-1:0] if_addr,
  output logic [31:0]   if_data,
  input  logic          d_en,
  input  logic          d_we,
  input  logic [1:0]    d_size,
  input  logic [31:0]   d_addr,
  input  logic [31:0]   d_wdata,
  output logic [31:0]   d_rdata
);

  assign boot_pc = 32'(BOOT_WORD * 4);

  logic          oor;
  logic [AW-1:0] widx;
  logic          wr, rd;
  logic [3:0]    lane_we;
  logic [31:0]   wbytes;

  assign oor  = |d_addr[31:BAW];
  assign widx = d_addr[BAW-1:2];
  assign wr   = d_en & d_we & ~oor;
  assign rd   = d_en & ~d_we;

  always_comb begin
    case (d_size)
      2'd0: begin
        lane_we = 4'b0001 << d_addr[1:0];
        wbytes  = {4{d_wdata[7:0]}};
      end
      2'd1: begin
        lane_we = d_addr[1] ? 4'b1100 : 4'b0011;
        wbytes  = {2{d_wdata[15:0]}};
      end
      default: begin
        lane_we = 4'b1111;
        wbytes  = d_wdata;
      end
    endcase
  end

  logic [31:0] if_word, d_word;

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [7:0] bank [DEPTH];
    logic [7:0] if_b, d_b;

    initial begin
      for (int i = 0; i < DEPTH; i++)
        bank[i] = 8'((3 * i + 64 * k + INIT_SEED) % 256);
    end

    always_ff @(posedge clk)
      if (wr && lane_we[k]) bank[widx] <= wbytes[8*k +: 8];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        if_b <= '0;
        d_b  <= '0;
      end else begin
        if_b <= bank[if_addr];
        if (rd) d_b <= bank[widx];
      end
    end

    assign if_word[8*k +: 8] = if_b;
    assign d_word[8*k +: 8]  = d_b;
  end

  logic [1:0] size_q, off_q;
  logic       oor_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q <= 2'd2;
      off_q  <= '0;
      oor_q  <= 1'b0;
    end else if (rd) begin
      size_q <= d_size;
      off_q  <= d_addr[1:0];
      oor_q  <= oor;
    end
  end

  logic [7:0]  sel_b;
  logic [15:0] sel_h;
  assign sel_b = d_word[8*off_q +: 8];
  assign sel_h = off_q[1] ? d_word[31:16] : d_word[15:0];

  assign if_data = if_word;
  assign d_rdata = oor_q          ? '0 :
                   (size_q == 2'd0) ? {24'd0, sel_b} :
                   (size_q == 2'd1) ? {16'd0, sel_h} : d_word;

  p_oor_load_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (d_en && !d_we && (|d_addr[31:BAW])) |=> (d_rdata == 32'd0));

  p_byte_zext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (d_en && !d_we && d_size == 2'd0) |=> (d_rdata[31:8] == 24'd0));

  p_half_zext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (d_en && !d_we && d_size == 2'd1) |=> (d_rdata[31:16] == 16'd0));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !(d_en && !d_we)) |=> $stable(d_rdata));

  p_boot_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_pc[1:0] == 2'b00 && boot_pc[31:BAW] == '0));

endmodule

// File: tb/lane_mem_tb_top.sv
module lane_mem_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] boot_pc;
  logic [9:0]  if_addr = '0;
  logic [31:0] if_data;
  logic        d_en = 1'b0, d_we = 1'b0;
  logic [1:0]  d_size = 2'd0;
  logic [31:0] d_addr = '0, d_wdata = '0;
  logic [31:0] d_rdata;

  always #4 clk = ~clk;

  lane_mem dut_i (
    .clk(clk), .rst_n(rst_n), .boot_pc(boot_pc),
    .if_addr(if_addr), .if_data(if_data),
    .d_en(d_en), .d_we(d_we), .d_size(d_size),
    .d_addr(d_addr), .d_wdata(d_wdata), .d_rdata(d_rdata)
  );

  logic [31:0] model [1024];
  int vecs = 0, errs = 0;
  logic [31:0] exp_if = '0, exp_d = '0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ld(input logic [31:0] w, input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      2'd0: return {24'd0, w[8*off +: 8]};
      2'd1: return {16'd0, (off[1] ? w[31:16] : w[15:0])};
      default: return w;
    endcase
  endfunction

  task automatic op(input bit en, input bit we, input logic [1:0] sz, input logic [31:0] a,
                    input logic [31:0] wd, input logic [9:0] ia, input string req);
    bit oor;
    d_en = en; d_we = we; d_size = sz; d_addr = a; d_wdata = wd; if_addr = ia;
    oor = (a[31:12] != 0);
    exp_if = model[ia];
    if (en && !we) exp_d = oor ? 32'd0 : ld(model[a[11:2]], sz, a[1:0]);
    if (en && we && !oor) begin
      case (sz)
        2'd0: model[a[11:2]][8*a[1:0] +: 8] = wd[7:0];
        2'd1: if (a[1]) model[a[11:2]][31:16] = wd[15:0];
              else      model[a[11:2]][15:0]  = wd[15:0];
        default: model[a[11:2]] = wd;
      endcase
    end
    @(posedge clk); @(negedge clk);
    chk({req, " fetch"}, if_data, exp_if);
    chk({req, " load"}, d_rdata, exp_d);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++)
      for (int k = 0; k < 4; k++)
        model[i][8*k +: 8] = 8'((3 * i + 64 * k + 8'h3C) % 256);
  end

  initial begin
    void'($urandom(32'd20240507));
    repeat (3) @(negedge clk);
    chk("R2 reset if_data", if_data, 32'd0);
    chk("R2 reset d_rdata", d_rdata, 32'd0);
    chk("R2 boot_pc", boot_pc, 32'h0000018C);
    rst_n = 1'b1;

    op(0, 0, 0, 0, 0, boot_pc[11:2], "R3 boot fetch");
    op(0, 0, 0, 0, 0, 10'd100, "R3 next fetch");
    op(1, 0, 0, 32'h18C, 0, 10'd99, "R9 byte at 0x18C");
    chk("R9 lowest byte of word 99", d_rdata, {24'd0, model[99][7:0]});
    op(1, 0, 2, 32'h190, 0, 10'd0, "R4 word load");
    for (int o = 1; o < 4; o++) op(1, 0, 0, 32'h190 + o, 0, 10'd1, "R5 byte offset");
    op(1, 0, 1, 32'h192, 0, 10'd2, "R6 upper half");
    op(1, 0, 1, 32'h193, 0, 10'd2, "R6 odd half");
    op(1, 0, 1, 32'h191, 0, 10'd2, "R6 lower half");
    op(1, 1, 0, 32'h201, 32'hAABBCCDD, 10'd3, "R7 byte store");
    op(0, 0, 0, 0, 0, 10'd3, "R4 idle hold");
    op(1, 0, 2, 32'h200, 0, 10'd128, "R7 readback");
    op(1, 1, 1, 32'h206, 32'h99991234, 10'd4, "R8 half store");
    op(1, 0, 2, 32'h204, 0, 10'd129, "R8 half readback");
    op(1, 1, 2, 32'h20B, 32'h0BADF00D, 10'd4, "R8 word store offset");
    op(1, 1, 3, 32'h20C, 32'hCAFE0001, 10'd4, "R8 size 3 store");
    op(1, 0, 2, 32'h208, 0, 10'd130, "R8 readback 2");
    op(1, 0, 2, 32'h20C, 0, 10'd131, "R9 shared store fetch");
    op(1, 1, 2, 32'h0C8, 32'h12345678, 10'd50, "R10 collision");
    op(0, 0, 0, 0, 0, 10'd50, "R10 after collision");
    chk("R10 new word", if_data, 32'h12345678);
    op(1, 1, 2, 32'h1200, 32'hFFFFFFFF, 10'd0, "R11 oor store");
    op(1, 0, 2, 32'h200, 0, 10'd128, "R11 alias untouched");
    op(1, 0, 2, 32'h80000200, 0, 10'd0, "R11 oor load");

    for (int n = 0; n < 6000; n++) begin
      logic [31:0] a;
      logic [9:0]  ia;
      a  = ($urandom % 8 == 0) ? $urandom : ($urandom % 4096);
      ia = ($urandom % 4 == 0) ? a[11:2] : 10'($urandom);
      op($urandom % 5 != 0, $urandom % 2 == 1, 2'($urandom), a, $urandom, ia, "R1 random");
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      errs++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule